// File: doc/BRIEF.md
# Programmable Modulus Clock Prescaler

This block divides the system clock by a programmable ratio. It emits a clock-enable pulse that lasts one cycle, and downstream counters use that pulse as their time base. A 4-bit modulus code sets the ratio:

- Code 0 divides by sixteen.
- Codes 2 through 15 divide by their own value.
- Code 1 silences the output entirely.

A single 16-bit control word holds the settings. It sits behind one register select, and software writes and reads it through a plain bus. The word holds three fields:

- an enable flag;
- a permission flag, which lets an external freeze line pause the counter;
- the modulus code.

Pausing keeps the count, so counting later continues where it stopped. A modulus written while the counter runs waits for the current period to finish. It is picked up when the count reaches one. While the block is disabled, the counter keeps reloading from the stored code. The first pulse after enabling therefore arrives exactly one full period after the enabling write.

Top module: `clk_prescaler`

## Requirements
- R1: After reset the control word reads 0x0000 and `tickOut` is low.
- R2: A write is taken when `sel` and `wrEn` are both high at a clock edge. The control word is laid out as follows:
  - bit 15 is the enable flag;
  - bit 14 is the freeze permission;
  - bits 3:0 are the modulus code;
  - bits 13:4 always read 0.
- R3: Driving `wrEn` with `sel` low leaves the control word unchanged.
- R4: While running with code N in 2..15, `tickOut` is high for one cycle out of every N cycles. It is never high in two consecutive cycles.
- R5: Code 0 gives one pulse every 16 cycles.
- R6: Code 1 produces no pulse at all.
- R7: With the enable flag at 0, `tickOut` stays low. The first pulse after a write that sets the enable flag is seen N cycles after that write's clock edge.
- R8: When the freeze permission and `freezeIn` are both high, the count holds and `tickOut` stays low. `freezeIn` has no effect while the permission is 0.
- R9: When a freeze ends, counting resumes from the held count without a reload. The pulse is delayed by exactly the number of frozen cycles.
- R10: A modulus written while enabled does not change the pulse already in progress. The new period starts after that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register select |
| wrEn | input | 1 | Write strobe, qualified by `sel` |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Current control word |
| freezeIn | input | 1 | External freeze request |
| tickOut | output | 1 | Divided clock-enable pulse |

## Verification
Two functions can fall in the same cycle:

- A freeze can coincide with the terminal count. Both try to decide the counter's next value.
- A modulus write can land on the very edge where the count reaches one.

The bench provokes both directly. It places a freeze window around the terminal cycle and counts the cycles between pulses, expecting the nominal period plus the number of frozen cycles. It also writes a new code right after a pulse and expects the old period first. A long random run then mixes writes, freeze toggling and permission changes so that these collisions occur at every phase. A cycle-level reference model, written from the requirements, judges `tickOut` and `rdData` in every cycle.

// File: rtl/clk_prescaler_pkg.sv
package clk_prescaler_pkg;
  // Strobes from the control half to the counter half
  typedef struct packed {
    logic load;   // copy reload value into the counter
    logic dec;    // count down by one
    logic fire;   // raise the output pulse next cycle
  } pscStrobe_t;
endpackage

// File: rtl/clk_prescaler_ctrl.sv
module clk_prescaler_ctrl
  import clk_prescaler_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MOD_W  = 4,
  localparam int CNT_W = MOD_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              freezeIn,
  input  logic              termHit,
  output pscStrobe_t        stb,
  output logic [CNT_W-1:0]  loadVal,
  output logic [DATA_W-1:0] rdData
);
  localparam int EN_BIT  = DATA_W - 1;
  localparam int FRZ_BIT = DATA_W - 2;
  localparam logic [CNT_W-1:0] FULL_SPAN = CNT_W'(1) << MOD_W;
  localparam logic [MOD_W-1:0] MUTE_CODE = MOD_W'(1);

  logic             enReg;
  logic             frzReg;
  logic [MOD_W-1:0] modReg;
  logic             running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      frzReg <= 1'b0;
      modReg <= '0;
    end else if (sel && wrEn) begin
      enReg  <= wrData[EN_BIT];
      frzReg <= wrData[FRZ_BIT];
      modReg <= wrData[MOD_W-1:0];
    end
  end

  always_comb begin
    loadVal = (modReg == '0) ? FULL_SPAN : {1'b0, modReg};
    running = enReg && !(frzReg && freezeIn);
    stb.load = !enReg || (running && termHit);
    stb.dec  = running && !termHit;
    stb.fire = running && termHit && (modReg != MUTE_CODE);
  end

  always_comb begin
    rdData = '0;
    rdData[EN_BIT]      = enReg;
    rdData[FRZ_BIT]     = frzReg;
    rdData[MOD_W-1:0]   = modReg;
  end
endmodule

// File: rtl/clk_prescaler_dp.sv
module clk_prescaler_dp
  import clk_prescaler_pkg::*;
#(
  parameter int MOD_W  = 4,
  localparam int CNT_W = MOD_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  pscStrobe_t       stb,
  input  logic [CNT_W-1:0] loadVal,
  output logic             termHit,
  output logic [CNT_W-1:0] countVal,
  output logic             tickOut
);
  localparam logic [CNT_W-1:0] RESET_CNT = CNT_W'(1) << MOD_W;

  logic [CNT_W-1:0] cnt;
  logic             tickReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= RESET_CNT;
      tickReg <= 1'b0;
    end else begin
      if (stb.load)
        cnt <= loadVal;
      else if (stb.dec)
        cnt <= cnt - CNT_W'(1);
      tickReg <= stb.fire;
    end
  end

  assign termHit  = (cnt == CNT_W'(1));
  assign countVal = cnt;
  assign tickOut  = tickReg;
endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler
  import clk_prescaler_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MOD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              freezeIn,
  output logic              tickOut
);
  localparam int CNT_W = MOD_W + 1;

  pscStrobe_t       stb;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] countVal;
  logic             termHit;

  clk_prescaler_ctrl #(.DATA_W(DATA_W), .MOD_W(MOD_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sel      (sel),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .freezeIn (freezeIn),
    .termHit  (termHit),
    .stb      (stb),
    .loadVal  (loadVal),
    .rdData   (rdData)
  );

  clk_prescaler_dp #(.MOD_W(MOD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .loadVal  (loadVal),
    .termHit  (termHit),
    .countVal (countVal),
    .tickOut  (tickOut)
  );
endmodule

// File: rtl/clk_prescaler_chk.sv
module clk_prescaler_chk #(
  parameter int DATA_W = 16,
  parameter int MOD_W  = 4,
  localparam int CNT_W = MOD_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              freezeIn,
  input logic [DATA_W-1:0] rdData,
  input logic              tickOut,
  input logic [CNT_W-1:0]  countVal
);
  localparam int EN_BIT  = DATA_W - 1;
  localparam int FRZ_BIT = DATA_W - 2;
  localparam logic [CNT_W-1:0] FULL_SPAN = CNT_W'(1) << MOD_W;

  // R4
  tick_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |=> !tickOut);

  // R7
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[EN_BIT] |=> !tickOut);

  // R8
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[EN_BIT] && rdData[FRZ_BIT] && freezeIn) |=> (!tickOut && $stable(countVal)));

  // R6
  mute_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[MOD_W-1:0] == MOD_W'(1)) |=> !tickOut);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-3:MOD_W] == '0);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countVal != '0) && (countVal <= FULL_SPAN));
endmodule

bind clk_prescaler clk_prescaler_chk #(.DATA_W(DATA_W), .MOD_W(MOD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .freezeIn (freezeIn),
  .rdData   (rdData),
  .tickOut  (tickOut),
  .countVal (countVal)
);

// File: tb/clk_prescaler_tb.sv
module clk_prescaler_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        freezeIn = 1'b0;
  logic [15:0] rdData;
  logic        tickOut;

  int checks = 0;
  int fails = 0;
  bit modelOn = 1'b0;
  bit done = 1'b0;

  // model state
  bit       mEn, mFrz, mTick;
  bit [3:0] mMod;
  int       mCnt;

  always #2 clk = ~clk;

  clk_prescaler u_dut (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .freezeIn(freezeIn), .tickOut(tickOut)
  );

  function automatic int spanOf(bit [3:0] code);
    return (code == 4'd0) ? 16 : int'(code);
  endfunction

  function automatic logic [15:0] wordOf(bit en, bit frz, bit [3:0] code);
    return {en, frz, 10'b0, code};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, built from R2..R10
  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mFrz = 0; mMod = 0; mCnt = 16; mTick = 0;
    end else begin
      mTick = 0;
      if (!mEn) mCnt = spanOf(mMod);
      else if (!(mFrz && freezeIn)) begin
        if (mCnt == 1) begin
          mTick = (mMod != 4'd1);
          mCnt = spanOf(mMod);
        end else mCnt = mCnt - 1;
      end
      if (sel && wrEn) begin
        mEn = wrData[15]; mFrz = wrData[14]; mMod = wrData[3:0];
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn && rstN) begin
      check(tickOut === mTick, "R4/R8 model tickOut", int'(tickOut), int'(mTick));
      check(rdData === wordOf(mEn, mFrz, mMod), "R2 model rdData",
            int'(rdData), int'(wordOf(mEn, mFrz, mMod)));
    end
  end

  task automatic writeReg(logic [15:0] d);
    sel = 1; wrEn = 1; wrData = d;
    @(negedge clk);
    sel = 0; wrEn = 0;
  endtask

  task automatic countToTick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tickOut && n < 100);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int ticks;
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    // R1 reset state
    check(rdData === 16'h0000, "R1 rdData at reset", int'(rdData), 0);
    check(tickOut === 1'b0, "R1 tickOut at reset", int'(tickOut), 0);
    rstN = 1;
    @(negedge clk);
    check(rdData === 16'h0000, "R1 rdData after release", int'(rdData), 0);
    modelOn = 1;

    // R2 layout, reserved bits zero
    writeReg(16'hFFFF);
    check(rdData === 16'hC00F, "R2 all-ones write", int'(rdData), 16'hC00F);
    writeReg(16'h0000);
    check(rdData === 16'h0000, "R2 clear", int'(rdData), 0);

    // R3 write without select ignored
    sel = 0; wrEn = 1; wrData = 16'hFFFF;
    @(negedge clk);
    wrEn = 0;
    check(rdData === 16'h0000, "R3 unselected write", int'(rdData), 0);

    // R7 first pulse after enable
    writeReg(16'h0005);
    repeat (3) @(negedge clk);
    writeReg(16'h8005);
    countToTick(n);
    check(n == 5, "R7 first pulse delay", n, 5);
    countToTick(n);
    check(n == 5, "R4 period code 5", n, 5);

    // R4 sweep of codes 2..15
    for (int c = 2; c < 16; c++) begin
      writeReg(wordOf(0, 0, 4'(c)));
      writeReg(wordOf(1, 0, 4'(c)));
      countToTick(n);
      check(n == c, "R7 first pulse sweep", n, c);
      countToTick(n);
      check(n == c, "R4 period sweep", n, c);
    end

    // R5 code 0
    writeReg(16'h0000);
    writeReg(16'h8000);
    countToTick(n);
    check(n == 16, "R5 first pulse code 0", n, 16);
    countToTick(n);
    check(n == 16, "R5 period code 0", n, 16);

    // R6 code 1
    writeReg(16'h0001);
    writeReg(16'h8001);
    ticks = 0;
    repeat (40) begin
      @(negedge clk);
      if (tickOut) ticks++;
    end
    check(ticks == 0, "R6 code 1 silent", ticks, 0);

    // R8 freezeIn without permission
    writeReg(16'h0006);
    writeReg(16'h8006);
    countToTick(n);
    n = 0;
    do begin
      freezeIn = (n >= 2 && n < 6);
      @(negedge clk);
      n++;
    end while (!tickOut && n < 100);
    freezeIn = 0;
    check(n == 6, "R8 freeze not permitted", n, 6);

    // R9 permitted freeze delays by frozen cycles
    writeReg(16'h4006);
    writeReg(16'hC006);
    countToTick(n);
    n = 0;
    do begin
      freezeIn = (n >= 2 && n < 6);
      @(negedge clk);
      n++;
    end while (!tickOut && n < 100);
    freezeIn = 0;
    check(n == 10, "R9 resume from held count", n, 10);

    // R9 freeze spanning the terminal cycle
    countToTick(n);
    n = 0;
    do begin
      freezeIn = (n >= 4 && n < 11);
      @(negedge clk);
      n++;
    end while (!tickOut && n < 100);
    freezeIn = 0;
    check(n == 13, "R9 freeze across terminal", n, 13);

    // R10 modulus change mid-period
    writeReg(16'h0004);
    writeReg(16'h8004);
    countToTick(n);
    writeReg(16'h8007);
    countToTick(n);
    check(n + 1 == 4, "R10 old period kept", n + 1, 4);
    countToTick(n);
    check(n == 7, "R10 new period", n, 7);

    // random mix checked by the model
    for (int i = 0; i < 4000; i++) begin
      sel = ($urandom % 4) != 0;
      wrEn = ($urandom % 7) == 0;
      wrData = 16'($urandom);
      if (($urandom % 3) != 0) wrData[15] = 1'b1;
      freezeIn = ($urandom % 4) == 0;
      @(negedge clk);
    end
    sel = 0; wrEn = 0; freezeIn = 0;
    @(negedge clk);

    modelOn = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule